// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block guards a processor against runaway software. A 16-bit up-counter advances on each tick of one of two clock-enable sources. When the count reaches a limit picked from four, the block does one of two things. In watchdog mode it pulses a reset request. In interval mode it sets a sticky interrupt flag and keeps running. Software prevents the watchdog reset by writing a clear command before the limit is reached.

The block has a single 16-bit control register. A write is accepted only when its upper byte carries the unlock key 0x5A. A write with any other upper byte is treated as a fault: the block immediately requests a reset and leaves the configuration as it was. A reset that the block requests itself never changes the configuration. Only the external power-on reset returns the configuration to its defaults.

Top module: `wdt_guard`

## Requirements
- R1: While and after power-on reset (`rst_ni` low), the register reads 0x6900, `rst_req_o` is 0 and `irq_flag_o` is 0. The defaults are watchdog mode, the main tick source, hold off and limit select 00.
- R2: A write whose bits 15:8 differ from 0x5A sets `rst_req_o` high in the cycle after the write. The configuration is left unchanged and the counter restarts from zero.
- R3: A write with bits 15:8 equal to 0x5A stores hold (bit 7), mode (bit 4), source (bit 2) and limit select (bits 1:0). Reads return 0x69 in bits 15:8 and those fields in place. Bits 6, 5 and 3 read as 0.
- R4: Limit select 00/01/10/11 gives 32768/8192/512/64 ticks. With a tick every cycle, a limit of L ticks after a counter clear produces the event L cycles after the clearing edge.
- R5: `rst_req_o` is high for exactly one cycle. After a watchdog event the counter restarts from zero, so the next event follows L ticks later.
- R6: While bit 7 is 1, the counter keeps its value. When bit 7 returns to 0, counting resumes from that value.
- R7: In interval mode (bit 4 = 1), reaching the limit sets `irq_flag_o` and wraps the counter to zero. `rst_req_o` is never asserted. The flag stays set until it is cleared.
- R8: A one-cycle pulse on `flag_clr_i` clears `irq_flag_o`. If a new interval event happens in the same cycle, setting the flag wins.
- R9: Bit 2 = 0 counts `tick_main_i` only. Bit 2 = 1 counts `tick_aux_i` only.
- R10: A keyed write with bit 3 = 1 clears the counter to zero. Bit 3 is not stored.
- R11: A watchdog event leaves the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data: unlock key in bits 15:8, fields in bits 7:0 |
| rd_data_o | output | 16 | Register read value |
| tick_main_i | input | 1 | Main clock-source tick (clock enable) |
| tick_aux_i | input | 1 | Auxiliary clock-source tick (clock enable) |
| flag_clr_i | input | 1 | Clear strobe for the interval flag (write 1 to clear) |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_flag_o | output | 1 | Sticky interval interrupt flag |

## Verification
The bench measures the exact cycle count to the event for every limit select, including the 32768-tick default straight out of power-on. A tap taken from the wrong counter bit, or an off-by-one compare, shifts that count by a factor of two or by one cycle.

It also times the second event after a watchdog pulse and after an interval wrap. A counter that fails to restart or wrap would give a second period of the wrong length.

It sends a write with a wrong key that tries to set hold and interval mode. A design that checked the key loosely would latch those fields or miss the fault pulse. The hold test freezes the counter partway through a period and checks the remaining length after release. The source tests starve one tick input at a time, which exposes an inverted or ignored select.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned HOLD_POS = 7;
  localparam int unsigned MODE_POS = 4;
  localparam int unsigned CLR_POS  = 3;
  localparam int unsigned SRC_POS  = 2;
  localparam int unsigned LIM_W    = 2;

  typedef struct packed {
    logic             hold;
    logic             itv_mode;
    logic             src_aux;
    logic [LIM_W-1:0] lim_sel;
  } wdt_cfg_t;

  localparam wdt_cfg_t CFG_POR = '0;

  function automatic logic [REG_W-1:0] cfg_to_word(input logic [7:0] id, input wdt_cfg_t c);
    logic [REG_W-1:0] w;
    w              = '0;
    w[15:8]        = id;
    w[HOLD_POS]    = c.hold;
    w[MODE_POS]    = c.itv_mode;
    w[SRC_POS]     = c.src_aux;
    w[LIM_W-1:0]   = c.lim_sel;
    return w;
  endfunction

  function automatic wdt_cfg_t word_to_cfg(input logic [REG_W-1:0] w);
    wdt_cfg_t c;
    c.hold     = w[HOLD_POS];
    c.itv_mode = w[MODE_POS];
    c.src_aux  = w[SRC_POS];
    c.lim_sel  = w[LIM_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_guard_pkg::*;
#(
  parameter logic [7:0] KEY = 8'h5A,
  parameter logic [7:0] ID  = 8'h69
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output wdt_cfg_t         cfg_o,
  output logic             cnt_clr_o,
  output logic             bad_key_o,
  output logic [REG_W-1:0] rd_data_o
);
  wdt_cfg_t cfg_q;
  logic     key_match, good_wr;

  assign key_match = (wr_data_i[15:8] == KEY);
  assign good_wr   = wr_en_i && key_match;
  assign bad_key_o = wr_en_i && !key_match;
  assign cnt_clr_o = good_wr && wr_data_i[CLR_POS];

  // only power-on reset touches the configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= CFG_POR;
    else if (good_wr) cfg_q <= word_to_cfg(wr_data_i);
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = cfg_to_word(ID, cfg_q);

  assert_cfg_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !good_wr |=> $stable(cfg_q));
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int unsigned N_SRC = 2,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] ticks_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  assign tick_o = ticks_i[sel_i];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_TAP = 4,
  parameter int unsigned TAP_W = 5,
  parameter logic [N_TAP*TAP_W-1:0] TAPS = {5'd6, 5'd9, 5'd13, 5'd15},
  localparam int unsigned SEL_W = $clog2(N_TAP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] tap_sel_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [N_TAP-1:0] tap_full;
  logic             advance;

  for (genvar g = 0; g < N_TAP; g++) begin : g_tap
    localparam int unsigned TB = int'(TAPS[g*TAP_W +: TAP_W]);
    localparam logic [CNT_W-1:0] MASK = {CNT_W{1'b1}} >> (CNT_W - TB);
    assign tap_full[g] = ((cnt_q & MASK) == MASK);
  end

  assign advance = tick_i && !hold_i && !clr_i;
  assign hit_o   = advance && tap_full[tap_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || hit_o)   cnt_q <= '0;
    else if (advance)          cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i) |=> $stable(cnt_q));
  assert_restart_after_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter logic [7:0]  KEY   = 8'h5A,
  parameter logic [7:0]  ID    = 8'h69,
  parameter logic [19:0] TAPS  = {5'd6, 5'd9, 5'd13, 5'd15}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  input  logic        tick_main_i,
  input  logic        tick_aux_i,
  input  logic        flag_clr_i,
  output logic        rst_req_o,
  output logic        irq_flag_o
);
  localparam int unsigned N_SRC = 2;

  wdt_cfg_t cfg;
  logic     cnt_clr, bad_key, tick, hit;
  logic     rst_req_q, irq_q;

  wdt_ctrl_reg #(.KEY(KEY), .ID(ID)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .cnt_clr_o (cnt_clr),
    .bad_key_o (bad_key),
    .rd_data_o (rd_data_o)
  );

  wdt_tick_sel #(.N_SRC(N_SRC)) u_tick_sel (
    .ticks_i ({tick_aux_i, tick_main_i}),
    .sel_i   (cfg.src_aux),
    .tick_o  (tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .N_TAP(4), .TAP_W(5), .TAPS(TAPS)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .hold_i    (cfg.hold),
    .clr_i     (cnt_clr | bad_key),
    .tap_sel_i (cfg.lim_sel),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rst_req_q <= bad_key | (hit & ~cfg.itv_mode);
      irq_q     <= (hit & cfg.itv_mode) | (irq_q & ~flag_clr_i);
    end
  end

  assign rst_req_o  = rst_req_q;
  assign irq_flag_o = irq_q;

  assert_bad_key_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[15:8] != KEY) |=> rst_req_o);
  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !bad_key) |=> !rst_req_o);
  assert_interval_no_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cfg.itv_mode && !bad_key) |=> (irq_flag_o && !rst_req_o));
  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !(hit && cfg.itv_mode)) |=> !irq_flag_o);
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, tick_main, tick_aux, flag_clr;
  logic [15:0] wr_data, rd_data;
  logic        rst_req, irq_flag;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  wdt_guard u_wdt_guard (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .tick_main_i (tick_main),
    .tick_aux_i  (tick_aux),
    .flag_clr_i  (flag_clr),
    .rst_req_o   (rst_req),
    .irq_flag_o  (irq_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_evt(input bit want_irq, input int start, input int max,
                          output int n, output bit other);
    n = start; other = 1'b0;
    while (n < max) begin
      @(negedge clk);
      n++;
      if (want_irq) begin
        if (rst_req) other = 1'b1;
        if (irq_flag) break;
      end else begin
        if (irq_flag) other = 1'b1;
        if (rst_req) break;
      end
    end
  endtask

  task automatic quiet(input string req, input int cycles);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req || irq_flag) hits++;
    end
    check(req, hits, 0);
  endtask

  task automatic pulse_clr_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int  n;
    bit  oth;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    tick_main = 1'b1; tick_aux = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset read", rd_data, 16'h6900);
    check("R1 reset rst_req", rst_req, 0);
    check("R1 reset flag", irq_flag, 0);
    rst_n = 1'b1;

    // R4 default limit 32768 from power-on
    wait_evt(0, 0, 32800, n, oth);
    check("R4 default limit", n, 32768);
    @(negedge clk);
    check("R5 pulse width", rst_req, 0);
    check("R1 still default after wdt reset", rd_data, 16'h6900);

    // R3/R10 keyed write, reserved bits and clear bit read 0
    wr(16'h5A6B);
    check("R3 R10 readback", rd_data, 16'h6903);
    wait_evt(0, 0, 100, n, oth);
    check("R4 R10 limit 64 after clear", n, 64);
    check("R4 no flag in watchdog mode", oth, 0);
    @(negedge clk);
    check("R5 single cycle", rst_req, 0);
    wait_evt(0, 65, 200, n, oth);
    check("R5 restart from zero", n, 128);
    check("R11 cfg kept after wdt reset", rd_data, 16'h6903);

    wr(16'h5A0A);
    wait_evt(0, 0, 600, n, oth);
    check("R4 limit 512", n, 512);
    wr(16'h5A09);
    wait_evt(0, 0, 8300, n, oth);
    check("R4 limit 8192", n, 8192);

    // R2 wrong key tries hold + interval
    wr(16'h5A0B);
    repeat (10) @(negedge clk);
    wr(16'hA598);
    check("R2 bad key pulse", rst_req, 1);
    check("R2 cfg unchanged", rd_data, 16'h6903);
    @(negedge clk);
    check("R2 R5 pulse ends", rst_req, 0);
    wait_evt(0, 1, 100, n, oth);
    check("R2 counter restarted", n, 64);

    // R6 hold mid-period
    wr(16'h5A0B);
    repeat (30) @(negedge clk);
    wr(16'h5A83);
    check("R6 hold readback", rd_data, 16'h6983);
    quiet("R6 held no event", 200);
    wr(16'h5A03);
    wait_evt(0, 0, 100, n, oth);
    check("R6 resume from held count", n, 33);

    // R9 source select
    wr(16'h5A0F);
    quiet("R9 aux selected ignores main", 200);
    tick_aux = 1'b1;
    wait_evt(0, 0, 100, n, oth);
    check("R9 aux counts", n, 64);
    tick_main = 1'b0;
    wr(16'h5A0B);
    quiet("R9 main selected ignores aux", 200);
    tick_main = 1'b1;
    wait_evt(0, 0, 100, n, oth);
    check("R9 main counts", n, 64);
    tick_aux = 1'b0;

    // R7/R8 interval mode
    wr(16'h5A1B);
    check("R7 interval readback", rd_data, 16'h6913);
    wait_evt(1, 0, 100, n, oth);
    check("R7 interval event at 64", n, 64);
    check("R7 no reset in interval", oth, 0);
    repeat (5) @(negedge clk);
    check("R7 flag sticky", irq_flag, 1);
    pulse_clr_flag();
    check("R8 flag cleared", irq_flag, 0);
    wait_evt(1, 70, 200, n, oth);
    check("R7 wrap period", n, 128);
    check("R7 no reset after wrap", oth, 0);
    pulse_clr_flag();
    check("R8 flag cleared again", irq_flag, 0);
    wr(16'h5A1A);
    wait_evt(1, 0, 600, n, oth);
    check("R7 interval limit 512", n, 512);
    check("R7 no reset at 512", oth, 0);
    pulse_clr_flag();
    check("R8 flag cleared at 512", irq_flag, 0);
    check("R11 cfg after interval", rd_data, 16'h6912);

    summary();
    $finish;
  end
endmodule